// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block is the receive half of an asynchronous serial port. It watches one serial input line. It detects the falling edge of a start bit and times every bit of the frame from a free-running oversampling enable, `os_tick`. Each bit is decided by a vote of three samples taken around the bit centre. The block assembles the data bits, checks the optional parity bit and the first stop bit, and writes the word into a one-word receive buffer. A one-clock strobe announces the write, and a read-acknowledge input frees the buffer again.

The frame shape is set at run time: 5 to 9 data bits, one or two stop bits, and no, even or odd parity. Double-speed mode halves the oversampling per bit, so the same tick rate gives twice the bit rate. Multi-processor mode keeps only address frames, which are frames whose ninth bit is set. The configuration is captured at each start edge, except the multi-processor enable, which is read when the frame completes. The tick divider and any register or bus access are outside this block.

Top module: `serial_rx`

## Requirements
- R1: `cfg_len` selects the number of data bits: codes 0, 1, 2, 3 and 4 give 5, 6, 7, 8 and 9 bits, and codes 5 to 7 behave as 9. The word appears right-aligned on `rx_data`, and the bits above the frame length read as zero.
- R2: `cfg_two_stop`=1 makes the frame carry two stop bits. Only the first stop bit is checked, so a low second stop bit leaves `err_frame` at 0 and the word is still delivered.
- R3: `cfg_par` selects parity: 2'b10 is even, 2'b11 is odd, and 2'b00 or 2'b01 means there is no parity bit. With parity on, `err_parity` is 1 for the buffered word when the received parity bit does not match the data. The data bits plus a correct parity bit hold an even number of ones in even mode and an odd number in odd mode.
- R4: `err_frame` is 1 for the buffered word when its first stop bit was sampled low. It is 0 when that bit was high.
- R5: A kept frame may complete while `rx_full`=1 and `rd_ack`=0. In that case `err_overrun` becomes 1, `rx_data` keeps the older word and no `rx_valid` pulse occurs. `rd_ack` clears `err_overrun`.
- R6: A falling edge starts a frame only if the start bit is still low at its centre. Otherwise the receiver goes back to idle and delivers nothing.
- R7: Each bit is the 2-of-3 majority of samples taken at oversample counts mid-1, mid and mid+1. One corrupted sample does not change the received bit.
- R8: Normal mode uses 16 oversample ticks per bit (mid = 8). Double-speed mode (`cfg_dbl`=1) uses 8 ticks per bit (mid = 4).
- R9: With `cfg_mp`=1, a completed frame whose bit 8 is 0 is discarded: there is no `rx_valid` pulse, `rx_full` is unchanged and no overrun is raised. A frame with bit 8 set is delivered.
- R10: `rx_valid` is high for exactly one clock when a word is written, and `rx_full` is 1 from that clock on. `rd_ack` clears `rx_full`.
- R11: The first data bit on the line is bit 0 of `rx_data` (LSB first).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input line, high when idle |
| os_tick | input | 1 | Oversampling enable, one clock wide |
| cfg_len | input | 3 | Data length code (0..4 give 5..9 bits) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_par | input | 2 | Parity mode: 10 even, 11 odd, 0x none |
| cfg_dbl | input | 1 | Double-speed mode (8 ticks per bit) |
| cfg_mp | input | 1 | Multi-processor mode: keep address frames only |
| rd_ack | input | 1 | Read acknowledge, frees the buffer |
| rx_data | output | 9 | Buffered received word |
| rx_valid | output | 1 | One-clock strobe when a word is written |
| rx_full | output | 1 | Buffer holds an unread word |
| err_frame | output | 1 | Framing error of the buffered word |
| err_parity | output | 1 | Parity error of the buffered word |
| err_overrun | output | 1 | A frame was lost because the buffer was full |

## Verification
Frames are sent with every data length, using a pattern of alternating bits. Wrong masking of the upper bits or a wrong bit count then shows in the received value. A lone low first bit separates LSB-first assembly from MSB-first. Parity is tried correct and inverted in both senses, and the unused code is checked as no parity. Each stop-bit configuration gets a low first stop bit and a low second stop bit, which shows which stop bit is checked. Short low pulses on the idle line test false-start rejection, and narrow glitches inside data and start bits test the 2-of-3 vote. A back-to-back pair of frames without an acknowledge shows overrun and that the older word is held. Double-speed frames use a shorter bit time. Data frames and address frames in multi-processor mode show that only address frames are delivered.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int DW = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_t;

  // data bits selected by a length code; codes above 4 act as 9
  function automatic logic [3:0] len_bits(input logic [2:0] code);
    return (code > 3'd4) ? 4'd9 : (4'd5 + {1'b0, code});
  endfunction

  // shift register fills from the top; move the word down to bit 0
  function automatic logic [DW-1:0] align_word(input logic [DW-1:0] sh,
                                              input logic [2:0] code);
    return sh >> (4'd9 - len_bits(code));
  endfunction

  function automatic logic majority3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // parity bit a correct sender appends
  function automatic logic parity_expect(input logic [DW-1:0] word, input logic odd);
    return (^word) ^ odd;
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '1;
      prev <= 1'b1;
    end else begin
      sr   <= {sr[STAGES-2:0], din};
      prev <= sr[STAGES-1];
    end
  end

  assign dout = sr[STAGES-1];
  assign fall = prev & ~sr[STAGES-1];

endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic dbl,
  input  logic din,
  output logic bit_strb,
  output logic bit_val
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST_N = CW'(OSR - 1);
  localparam logic [CW-1:0] LAST_D = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] MID_N  = CW'(OSR / 2);
  localparam logic [CW-1:0] MID_D  = CW'(OSR / 4);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic [CW-1:0] mid;
  logic          s0, s1;

  assign last = dbl ? LAST_D : LAST_N;
  assign mid  = dbl ? MID_D  : MID_N;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      s0       <= 1'b1;
      s1       <= 1'b1;
      bit_strb <= 1'b0;
      bit_val  <= 1'b1;
    end else begin
      bit_strb <= 1'b0;
      if (!run) begin
        cnt <= '0;
      end else if (tick) begin
        cnt <= (cnt == last) ? '0 : cnt + CW'(1);
        if (cnt == mid - CW'(1)) s0 <= din;
        if (cnt == mid)          s1 <= din;
        if (cnt == mid + CW'(1)) begin
          bit_strb <= 1'b1;
          bit_val  <= majority3(s0, s1, din);
        end
      end
    end
  end

  AST_STRB_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strb |-> $past(run)); // R7

  AST_COUNT_IN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dbl) |-> (cnt < CW'(OSR / 2))); // R8

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic          bit_strb,
  input  logic          bit_val,
  input  logic [2:0]    cfg_len,
  input  logic [1:0]    cfg_par,
  input  logic          cfg_two_stop,
  input  logic          cfg_dbl,
  output logic          run,
  output logic          dbl_q,
  output logic          frame_done,
  output logic [DW-1:0] frame_data,
  output logic          frame_perr,
  output logic          frame_ferr
);
  rx_state_t     state;
  logic [2:0]    len_q;
  logic [1:0]    par_q;
  logic          two_q;
  logic [3:0]    nbit;
  logic [3:0]    need;
  logic [DW-1:0] sh;
  logic [DW-1:0] word;
  logic          perr_q, ferr_q, done_q;

  assign need = len_bits(len_q);
  assign word = align_word(sh, len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      len_q  <= '0;
      par_q  <= '0;
      two_q  <= 1'b0;
      dbl_q  <= 1'b0;
      nbit   <= '0;
      sh     <= '0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (fall) begin
          state  <= ST_START;
          len_q  <= cfg_len;
          par_q  <= cfg_par;
          two_q  <= cfg_two_stop;
          dbl_q  <= cfg_dbl;
          nbit   <= '0;
          sh     <= '0;
          perr_q <= 1'b0;
          ferr_q <= 1'b0;
        end
        ST_START: if (bit_strb) state <= bit_val ? ST_IDLE : ST_DATA;
        ST_DATA: if (bit_strb) begin
          sh   <= {bit_val, sh[DW-1:1]};
          nbit <= nbit + 4'd1;
          if (nbit + 4'd1 == need) state <= par_q[1] ? ST_PAR : ST_STOP1;
        end
        ST_PAR: if (bit_strb) begin
          perr_q <= (bit_val != parity_expect(word, par_q[0]));
          state  <= ST_STOP1;
        end
        ST_STOP1: if (bit_strb) begin
          ferr_q <= ~bit_val;
          if (two_q) state <= ST_STOP2;
          else begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        ST_STOP2: if (bit_strb) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign run        = (state != ST_IDLE);
  assign frame_done = done_q;
  assign frame_data = word;
  assign frame_perr = perr_q;
  assign frame_ferr = ferr_q;

  AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && bit_strb && bit_val) |=> (state == ST_IDLE && !frame_done)); // R6

  AST_IDLE_WAITS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !fall) |=> (state == ST_IDLE)); // R6

  AST_SECOND_STOP_NO_FERR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP2) |=> $stable(ferr_q)); // R2

  AST_DATA_FITS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ((frame_data >> need) == '0)); // R1

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
  import serial_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_done,
  input  logic [DW-1:0] frame_data,
  input  logic          frame_perr,
  input  logic          frame_ferr,
  input  logic          cfg_mp,
  input  logic          rd_ack,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_full,
  output logic          err_frame,
  output logic          err_parity,
  output logic          err_overrun
);
  logic drop_mp, keep, room, write, lost;

  assign drop_mp = frame_done && cfg_mp && !frame_data[DW-1];
  assign keep    = frame_done && !drop_mp;
  assign room    = !rx_full || rd_ack;
  assign write   = keep && room;
  assign lost    = keep && !room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      rx_full     <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      rx_valid <= write;
      if (write) begin
        rx_data     <= frame_data;
        err_frame   <= frame_ferr;
        err_parity  <= frame_perr;
        rx_full     <= 1'b1;
        err_overrun <= 1'b0;
      end else begin
        if (rd_ack) begin
          rx_full     <= 1'b0;
          err_overrun <= 1'b0;
        end
        if (lost) err_overrun <= 1'b1;
      end
    end
  end

  AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R10

  AST_VALID_MEANS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_full); // R10

  AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !frame_done) |=> !rx_full); // R10

  AST_OVERRUN_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !drop_mp && rx_full && !rd_ack) |=>
      (err_overrun && $stable(rx_data) && !rx_valid)); // R5

  AST_MP_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    drop_mp |=> (!rx_valid && $stable(rx_full) && $stable(err_overrun))); // R9

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic          os_tick,
  input  logic [2:0]    cfg_len,
  input  logic          cfg_two_stop,
  input  logic [1:0]    cfg_par,
  input  logic          cfg_dbl,
  input  logic          cfg_mp,
  input  logic          rd_ack,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_full,
  output logic          err_frame,
  output logic          err_parity,
  output logic          err_overrun
);
  logic          line_s, line_fall;
  logic          run, dbl_q, bit_strb, bit_val;
  logic          frame_done, frame_perr, frame_ferr;
  logic [DW-1:0] frame_data;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s), .fall(line_fall)
  );

  serial_rx_sampler #(.OSR(OSR)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .run(run), .dbl(dbl_q),
    .din(line_s), .bit_strb(bit_strb), .bit_val(bit_val)
  );

  serial_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .fall(line_fall), .bit_strb(bit_strb),
    .bit_val(bit_val), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_two_stop(cfg_two_stop), .cfg_dbl(cfg_dbl), .run(run), .dbl_q(dbl_q),
    .frame_done(frame_done), .frame_data(frame_data),
    .frame_perr(frame_perr), .frame_ferr(frame_ferr)
  );

  serial_rx_buffer u_buffer (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
    .frame_perr(frame_perr), .frame_ferr(frame_ferr), .cfg_mp(cfg_mp),
    .rd_ack(rd_ack), .rx_data(rx_data), .rx_valid(rx_valid), .rx_full(rx_full),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
  );

endmodule

// File: tb/tb_serial_rx.sv
`timescale 1ns/1ps
module tb_serial_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       os_tick = 1'b0;
  logic [2:0] cfg_len = 3'd3;
  logic       cfg_two_stop = 1'b0;
  logic [1:0] cfg_par = 2'b00;
  logic       cfg_dbl = 1'b0;
  logic       cfg_mp = 1'b0;
  logic       rd_ack = 1'b0;
  logic [8:0] rx_data;
  logic       rx_valid, rx_full, err_frame, err_parity, err_overrun;

  int nchk = 0, nerr = 0, vcount = 0, pulse_bad = 0;
  bit prev_v = 1'b0, finished = 1'b0;

  serial_rx dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick), .cfg_len(cfg_len),
    .cfg_two_stop(cfg_two_stop), .cfg_par(cfg_par), .cfg_dbl(cfg_dbl),
    .cfg_mp(cfg_mp), .rd_ack(rd_ack), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_full(rx_full), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun)
  );

  always #4 clk = ~clk;

  // oversample tick every 4 clocks: 64 clocks per bit normal, 32 double
  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      t = (t + 1) % 4;
      os_tick = (t == 0);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        vcount++;
        if (prev_v) pulse_bad++;
      end
      prev_v = rx_valid;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] len, input logic [1:0] par, input bit two,
                         input bit dbl, input bit mp);
    cfg_len = len; cfg_par = par; cfg_two_stop = two; cfg_dbl = dbl; cfg_mp = mp;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] d, input int nb, input logic [1:0] pm,
                            input bit pflip, input bit s1, input bit s2, input bit two,
                            input int bc, input int gbit);
    logic seq [16];
    int   n = 0;
    logic p = 1'b0;
    seq[n++] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      seq[n++] = d[i];
      p ^= d[i];
    end
    if (pm[1]) seq[n++] = p ^ pm[0] ^ pflip;
    seq[n++] = s1;
    if (two) seq[n++] = s2;
    for (int k = 0; k < n; k++) begin
      if (k == gbit) begin
        rxd = seq[k];  repeat (bc / 2 - 2) @(negedge clk);
        rxd = ~seq[k]; repeat (3) @(negedge clk);
        rxd = seq[k];  repeat (bc - bc / 2 - 1) @(negedge clk);
      end else begin
        rxd = seq[k];
        repeat (bc) @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (2 * bc) @(negedge clk);
  endtask

  task automatic ack();
    rd_ack = 1'b1; @(negedge clk);
    rd_ack = 1'b0; @(negedge clk);
  endtask

  task automatic expect_word(input string tag, input int v0, input logic [8:0] e,
                             input bit ef, input bit ep);
    check(tag, "valid pulses", vcount - v0, 1);
    check(tag, "rx_data", int'(rx_data), int'(e));
    check(tag, "rx_full", int'(rx_full), 1);
    check(tag, "err_frame", int'(err_frame), int'(ef));
    check(tag, "err_parity", int'(err_parity), int'(ep));
    ack();
    check(tag, "rx_full after ack", int'(rx_full), 0);
  endtask

  task automatic t_reset();
    check("R10", "reset rx_full", int'(rx_full), 0);
    check("R10", "reset rx_valid", int'(rx_valid), 0);
    check("R5", "reset err_overrun", int'(err_overrun), 0);
    check("R4", "reset err_frame", int'(err_frame), 0);
  endtask

  task automatic t_lengths();
    for (int L = 5; L <= 9; L++) begin
      int v0;
      set_cfg(3'(L - 5), 2'b00, 1'b0, 1'b0, 1'b0);
      v0 = vcount;
      send_frame(9'h155, L, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
      expect_word("R1", v0, 9'h155 & 9'((1 << L) - 1), 1'b0, 1'b0);
    end
    set_cfg(3'd7, 2'b00, 1'b0, 1'b0, 1'b0);
    begin
      int v0 = vcount;
      send_frame(9'h1AA, 9, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
      expect_word("R1", v0, 9'h1AA, 1'b0, 1'b0);
    end
  endtask

  task automatic t_lsb_first();
    int v0;
    set_cfg(3'd3, 2'b00, 1'b0, 1'b0, 1'b0);
    v0 = vcount;
    send_frame(9'h001, 8, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
    expect_word("R11", v0, 9'h001, 1'b0, 1'b0);
  endtask

  task automatic t_parity();
    int v0;
    set_cfg(3'd3, 2'b10, 1'b0, 1'b0, 1'b0);
    v0 = vcount; send_frame(9'h037, 8, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
    expect_word("R3", v0, 9'h037, 1'b0, 1'b0);
    v0 = vcount; send_frame(9'h037, 8, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 64, -1);
    expect_word("R3", v0, 9'h037, 1'b0, 1'b1);
    set_cfg(3'd3, 2'b11, 1'b0, 1'b0, 1'b0);
    v0 = vcount; send_frame(9'h0C3, 8, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
    expect_word("R3", v0, 9'h0C3, 1'b0, 1'b0);
    v0 = vcount; send_frame(9'h0C3, 8, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 64, -1);
    expect_word("R3", v0, 9'h0C3, 1'b0, 1'b1);
    set_cfg(3'd3, 2'b01, 1'b0, 1'b0, 1'b0);
    v0 = vcount; send_frame(9'h05A, 8, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
    expect_word("R3", v0, 9'h05A, 1'b0, 1'b0);
  endtask

  task automatic t_framing();
    int v0;
    set_cfg(3'd3, 2'b00, 1'b0, 1'b0, 1'b0);
    v0 = vcount; send_frame(9'h0E1, 8, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 64, -1);
    expect_word("R4", v0, 9'h0E1, 1'b1, 1'b0);
    v0 = vcount; send_frame(9'h01E, 8, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
    expect_word("R4", v0, 9'h01E, 1'b0, 1'b0);
  endtask

  task automatic t_two_stop();
    int v0;
    set_cfg(3'd3, 2'b00, 1'b1, 1'b0, 1'b0);
    v0 = vcount; send_frame(9'h092, 8, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 64, -1);
    expect_word("R2", v0, 9'h092, 1'b0, 1'b0);
    v0 = vcount; send_frame(9'h049, 8, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 64, -1);
    expect_word("R2", v0, 9'h049, 1'b1, 1'b0);
  endtask

  task automatic t_overrun();
    int v0;
    set_cfg(3'd3, 2'b00, 1'b0, 1'b0, 1'b0);
    v0 = vcount;
    send_frame(9'h011, 8, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
    send_frame(9'h022, 8, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
    check("R5", "valid pulses", vcount - v0, 1);
    check("R5", "err_overrun", int'(err_overrun), 1);
    check("R5", "older word kept", int'(rx_data), 'h11);
    ack();
    check("R5", "overrun cleared by ack", int'(err_overrun), 0);
    check("R5", "rx_full after ack", int'(rx_full), 0);
    v0 = vcount; send_frame(9'h033, 8, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
    check("R5", "no overrun next", int'(err_overrun), 0);
    expect_word("R5", v0, 9'h033, 1'b0, 1'b0);
  endtask

  task automatic t_false_start();
    int v0;
    set_cfg(3'd3, 2'b00, 1'b0, 1'b0, 1'b0);
    v0 = vcount;
    rxd = 1'b0; repeat (12) @(negedge clk);
    rxd = 1'b1; repeat (200) @(negedge clk);
    check("R6", "no word from short pulse", vcount - v0, 0);
    check("R6", "rx_full stays clear", int'(rx_full), 0);
    send_frame(9'h0A5, 8, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
    expect_word("R6", v0, 9'h0A5, 1'b0, 1'b0);
  endtask

  task automatic t_noise();
    int v0;
    set_cfg(3'd3, 2'b00, 1'b0, 1'b0, 1'b0);
    v0 = vcount; send_frame(9'h05A, 8, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, 3);
    expect_word("R7", v0, 9'h05A, 1'b0, 1'b0);
    v0 = vcount; send_frame(9'h0C6, 8, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, 0);
    expect_word("R7", v0, 9'h0C6, 1'b0, 1'b0);
    v0 = vcount; send_frame(9'h039, 8, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, 9);
    expect_word("R7", v0, 9'h039, 1'b0, 1'b0);
  endtask

  task automatic t_double();
    int v0;
    set_cfg(3'd4, 2'b10, 1'b0, 1'b1, 1'b0);
    v0 = vcount; send_frame(9'h1C3, 9, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 32, -1);
    expect_word("R8", v0, 9'h1C3, 1'b0, 1'b0);
    v0 = vcount; send_frame(9'h03C, 9, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 32, -1);
    expect_word("R8", v0, 9'h03C, 1'b1, 1'b0);
  endtask

  task automatic t_mp();
    int v0;
    set_cfg(3'd4, 2'b00, 1'b0, 1'b0, 1'b1);
    v0 = vcount; send_frame(9'h055, 9, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
    check("R9", "data frame discarded", vcount - v0, 0);
    check("R9", "rx_full stays clear", int'(rx_full), 0);
    v0 = vcount; send_frame(9'h155, 9, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64, -1);
    check("R9", "no overrun", int'(err_overrun), 0);
    expect_word("R9", v0, 9'h155, 1'b0, 1'b0);
    set_cfg(3'd3, 2'b00, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_lengths();
    t_lsb_first();
    t_parity();
    t_framing();
    t_two_stop();
    t_overrun();
    t_false_start();
    t_noise();
    t_double();
    t_mp();
    check("R10", "rx_valid pulses longer than one clock", pulse_bad, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule